// File: doc/BRIEF.md
# Operation-done status and interrupt controller

This block keeps track of whether a long nonvolatile storage operation is running, and raises an interrupt when one ends. Three sources can start an operation: a data word write, a write to a password or protection register, and a debug mass erase. When the block is idle it accepts one start request. It sends a one-cycle start pulse with an operation code to the storage engine and sets a WORKING status bit. The engine later reports completion, with or without an error. WORKING then clears, the interrupt status is set, and a sticky failure flag records whether a program step or an erase step went wrong.

Software sees the interrupt as one bit of a shared status word. It clears the bit by writing a one to it and gates it with a mask bit. A mass erase is honoured only when nothing is active. The intended sequence is a module soft reset, then a wait until WORKING reads 0, then the mass-erase request. A mass-erase request made while busy is dropped and flagged. A soft reset aborts the tracked operation without raising the interrupt.

Top module: `nvop_done_ctrl`

## Requirements
- R1: After reset, WORKING, the start pulse, the operation code, all failure flags, the raw and masked status words, the mask and the interrupt line are all 0.
- R2: While idle and with no soft reset, a start request makes WORKING 1 in the next cycle. In that same cycle the start pulse is 1 for exactly one cycle and the operation code shows the accepted kind (data write = 1, protection write = 2, mass erase = 3, none = 0).
- R3: Simultaneous start requests are resolved by fixed priority: mass erase first, then protection write, then data write.
- R4: Data or protection start requests made while WORKING is 1 have no effect. WORKING stays 1, the operation code is unchanged and no start pulse is issued.
- R5: A mass-erase request made while WORKING is 1 starts nothing and sets the erase-rejected flag in the next cycle. The flag stays set until the next accepted operation or a soft reset.
- R6: An engine done indication while WORKING is 1 clears WORKING and sets the raw interrupt status in the next cycle, whether or not the error indication is set. A done indication while idle changes nothing.
- R7: A done with error sets the program-failure flag for a data or protection operation, and sets the erase-failure flag for a mass erase. Both flags are sticky and clear when the next operation is accepted.
- R8: A soft reset clears WORKING, the operation code, both failure flags and the erase-rejected flag in the next cycle. It does not set the raw interrupt status. It overrides start requests and a done indication in the same cycle.
- R9: The raw and masked status words carry the interrupt at bit 2 and 0 in all other bits. A mask write loads the mask from bit 2 of its data. The masked bit and the interrupt line equal the raw bit AND the mask.
- R10: A clear write with bit 2 set clears the raw status in the next cycle, and a clear write with bit 2 clear has no effect. A completion in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Module soft reset pulse |
| wr_req_i | input | 1 | Data word write start request |
| prot_req_i | input | 1 | Password/protection register write start request |
| erase_req_i | input | 1 | Debug mass-erase enable request |
| eng_done_i | input | 1 | Storage engine completion pulse |
| eng_err_i | input | 1 | Error qualifier for eng_done_i |
| mask_wr_i | input | 1 | Interrupt mask write strobe |
| mask_data_i | input | STAT_W | Mask write data |
| clr_wr_i | input | 1 | Interrupt clear write strobe |
| clr_data_i | input | STAT_W | Clear write data (write one to clear) |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_op_o | output | 2 | Operation code of the current operation |
| working_o | output | 1 | WORKING status |
| prog_fail_o | output | 1 | Sticky program-failure flag |
| erase_fail_o | output | 1 | Sticky erase-failure flag |
| erase_rej_o | output | 1 | Sticky mass-erase-rejected flag |
| irq_raw_o | output | STAT_W | Raw interrupt status word |
| irq_mis_o | output | STAT_W | Masked interrupt status word |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong WORKING state shows up one cycle after the offending input. A missed completion leaves WORKING stuck at 1 and blocks every later start pulse. A spurious acceptance shows a start pulse and a changed operation code while busy. A raw status bit that is set wrongly, or not cleared, is visible on both status words and on the interrupt line in the next cycle, and stays there until a clear. A misplaced failure flag stays latched at the ports until the next accepted operation, so any later sample reveals it.

// File: rtl/nvop_pkg.sv
package nvop_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_DATA  = 2'd1,
        OP_PROT  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef struct packed {
        logic erase;
        logic prot;
        logic data;
    } req_t;

    typedef struct packed {
        logic prog_fail;
        logic erase_fail;
        logic erase_rej;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{prog_fail: 1'b0, erase_fail: 1'b0, erase_rej: 1'b0};

    function automatic op_e pick_op(input req_t r);
        if (r.erase)     return OP_ERASE;
        else if (r.prot) return OP_PROT;
        else if (r.data) return OP_DATA;
        else             return OP_NONE;
    endfunction

    function automatic logic is_program_kind(input op_e k);
        return (k == OP_DATA) || (k == OP_PROT);
    endfunction

endpackage

// File: rtl/nvop_arbiter.sv
module nvop_arbiter
    import nvop_pkg::*;
(
    input  req_t req_i,
    input  logic working_i,
    input  logic soft_rst_i,
    output logic accept_o,
    output op_e  acc_op_o,
    output logic erase_rej_evt_o
);

    op_e chosen;

    always_comb begin
        chosen          = pick_op(req_i);
        accept_o        = !working_i && !soft_rst_i && (chosen != OP_NONE);
        acc_op_o        = accept_o ? chosen : OP_NONE;
        erase_rej_evt_o = working_i && !soft_rst_i && req_i.erase;
    end

endmodule

// File: rtl/nvop_state.sv
module nvop_state
    import nvop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   soft_rst_i,
    input  req_t   req_i,
    input  logic   accept_i,
    input  op_e    acc_op_i,
    input  logic   erase_rej_evt_i,
    input  logic   done_i,
    input  logic   err_i,
    output logic   working_o,
    output op_e    op_o,
    output flags_t flags_o,
    output logic   start_o,
    output logic   complete_o
);

    logic   working_q;
    op_e    op_q;
    flags_t flags_q;
    logic   start_q;

    always_comb begin
        complete_o = working_q && done_i && !soft_rst_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            working_q <= 1'b0;
            op_q      <= OP_NONE;
            flags_q   <= FLAGS_CLEAR;
            start_q   <= 1'b0;
        end else if (soft_rst_i) begin
            working_q <= 1'b0;
            op_q      <= OP_NONE;
            flags_q   <= FLAGS_CLEAR;
            start_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (accept_i) begin
                working_q <= 1'b1;
                op_q      <= acc_op_i;
                flags_q   <= FLAGS_CLEAR;
                start_q   <= 1'b1;
            end else if (complete_o) begin
                working_q <= 1'b0;
                op_q      <= OP_NONE;
                if (err_i) begin
                    if (is_program_kind(op_q)) flags_q.prog_fail  <= 1'b1;
                    else                       flags_q.erase_fail <= 1'b1;
                end
            end
            if (erase_rej_evt_i) flags_q.erase_rej <= 1'b1;
        end
    end

    assign working_o = working_q;
    assign op_o      = op_q;
    assign flags_o   = flags_q;
    assign start_o   = start_q;

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (working_q && start_q && op_q != OP_NONE));

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (working_q && !done_i && !soft_rst_i) |=> (working_q && !start_q && op_q == $past(op_q)));

    a_r5_erase_rejected: assert property (@(posedge clk) disable iff (rst)
        (working_q && req_i.erase && !soft_rst_i) |=> flags_q.erase_rej);

    a_r6_done_clears_working: assert property (@(posedge clk) disable iff (rst)
        (working_q && done_i && !soft_rst_i) |=> !working_q);

    a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (!working_q && op_q == OP_NONE && flags_q == FLAGS_CLEAR && !start_q));

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

endmodule

// File: rtl/nvop_irq.sv
module nvop_irq #(
    parameter int STAT_W  = 8,
    parameter int IRQ_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              mask_wr_i,
    input  logic [STAT_W-1:0] mask_data_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    output logic [STAT_W-1:0] raw_word_o,
    output logic [STAT_W-1:0] mis_word_o,
    output logic              irq_o
);

    logic raw_q;
    logic mask_q;
    logic clr_hit;
    logic masked;

    assign clr_hit = clr_wr_i && clr_data_i[IRQ_BIT];
    assign masked  = raw_q && mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (set_i)        raw_q <= 1'b1;
            else if (clr_hit) raw_q <= 1'b0;
            if (mask_wr_i)    mask_q <= mask_data_i[IRQ_BIT];
        end
    end

    for (genvar g = 0; g < STAT_W; g++) begin : g_word
        if (g == IRQ_BIT) begin : g_live
            assign raw_word_o[g] = raw_q;
            assign mis_word_o[g] = masked;
        end else begin : g_zero
            assign raw_word_o[g] = 1'b0;
            assign mis_word_o[g] = 1'b0;
        end
    end

    assign irq_o = masked;

    a_r6_set_on_complete: assert property (@(posedge clk) disable iff (rst)
        set_i |=> raw_q);

    a_r10_clear_hit: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !set_i) |=> !raw_q);

    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!raw_q && !set_i) |=> !raw_q);

    a_r9_mask_load: assert property (@(posedge clk) disable iff (rst)
        mask_wr_i |=> (mask_q == $past(mask_data_i[IRQ_BIT])));

endmodule

// File: rtl/nvop_done_ctrl.sv
module nvop_done_ctrl
    import nvop_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int IRQ_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_i,
    input  logic              wr_req_i,
    input  logic              prot_req_i,
    input  logic              erase_req_i,
    input  logic              eng_done_i,
    input  logic              eng_err_i,
    input  logic              mask_wr_i,
    input  logic [STAT_W-1:0] mask_data_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    output logic              eng_start_o,
    output logic [1:0]        eng_op_o,
    output logic              working_o,
    output logic              prog_fail_o,
    output logic              erase_fail_o,
    output logic              erase_rej_o,
    output logic [STAT_W-1:0] irq_raw_o,
    output logic [STAT_W-1:0] irq_mis_o,
    output logic              irq_o
);

    req_t   req;
    logic   accept;
    op_e    acc_op;
    logic   rej_evt;
    logic   working;
    op_e    op_cur;
    flags_t flags;
    logic   complete;

    assign req = '{erase: erase_req_i, prot: prot_req_i, data: wr_req_i};

    nvop_arbiter u_arb (
        .req_i          (req),
        .working_i      (working),
        .soft_rst_i     (soft_rst_i),
        .accept_o       (accept),
        .acc_op_o       (acc_op),
        .erase_rej_evt_o(rej_evt)
    );

    nvop_state u_state (
        .clk            (clk),
        .rst            (rst),
        .soft_rst_i     (soft_rst_i),
        .req_i          (req),
        .accept_i       (accept),
        .acc_op_i       (acc_op),
        .erase_rej_evt_i(rej_evt),
        .done_i         (eng_done_i),
        .err_i          (eng_err_i),
        .working_o      (working),
        .op_o           (op_cur),
        .flags_o        (flags),
        .start_o        (eng_start_o),
        .complete_o     (complete)
    );

    nvop_irq #(
        .STAT_W (STAT_W),
        .IRQ_BIT(IRQ_BIT)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .set_i      (complete),
        .mask_wr_i  (mask_wr_i),
        .mask_data_i(mask_data_i),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .raw_word_o (irq_raw_o),
        .mis_word_o (irq_mis_o),
        .irq_o      (irq_o)
    );

    assign eng_op_o     = op_cur;
    assign working_o    = working;
    assign prog_fail_o  = flags.prog_fail;
    assign erase_fail_o = flags.erase_fail;
    assign erase_rej_o  = flags.erase_rej;

    a_r1_idle_no_op: assert property (@(posedge clk) disable iff (rst)
        !working |-> (op_cur == OP_NONE));

    a_r6_completion_raises_status: assert property (@(posedge clk) disable iff (rst)
        (working && eng_done_i && !soft_rst_i) |=> irq_raw_o[IRQ_BIT]);

endmodule

// File: tb/test_nvop_done_ctrl.sv
`timescale 1ns/1ps
module test_nvop_done_ctrl;

    localparam int W = 8;
    localparam logic [W-1:0] BIT2 = 8'h04;

    logic clk = 1'b0;
    logic rst;
    logic soft_rst, wr_req, prot_req, erase_req, eng_done, eng_err;
    logic mask_wr, clr_wr;
    logic [W-1:0] mask_data, clr_data;
    logic eng_start, working, prog_fail, erase_fail, erase_rej, irq;
    logic [1:0] eng_op;
    logic [W-1:0] irq_raw, irq_mis;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nvop_done_ctrl #(.STAT_W(W), .IRQ_BIT(2)) i_nvop_done_ctrl (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst),
        .wr_req_i(wr_req), .prot_req_i(prot_req), .erase_req_i(erase_req),
        .eng_done_i(eng_done), .eng_err_i(eng_err),
        .mask_wr_i(mask_wr), .mask_data_i(mask_data),
        .clr_wr_i(clr_wr), .clr_data_i(clr_data),
        .eng_start_o(eng_start), .eng_op_o(eng_op), .working_o(working),
        .prog_fail_o(prog_fail), .erase_fail_o(erase_fail), .erase_rej_o(erase_rej),
        .irq_raw_o(irq_raw), .irq_mis_o(irq_mis), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        soft_rst = 0; wr_req = 0; prot_req = 0; erase_req = 0;
        eng_done = 0; eng_err = 0; mask_wr = 0; clr_wr = 0;
        mask_data = '0; clr_data = '0;
    endtask

    task automatic request(input logic w, input logic p, input logic e);
        wr_req = w; prot_req = p; erase_req = e;
        step();
        quiet();
    endtask

    task automatic finish_op(input logic err);
        eng_done = 1; eng_err = err;
        step();
        quiet();
    endtask

    task automatic clear_irq(input logic [W-1:0] d);
        clr_wr = 1; clr_data = d;
        step();
        quiet();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        quiet();
        rst = 1;
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 working", working, 0);
        chk("R1 start", eng_start, 0);
        chk("R1 op", eng_op, 0);
        chk("R1 flags", {prog_fail, erase_fail, erase_rej}, 0);
        chk("R1 raw", irq_raw, 0);
        chk("R1 mis", irq_mis, 0);
        chk("R1 irq", irq, 0);

        // R2 / R3: sweep every request combination from idle
        for (int m = 0; m < 8; m++) begin
            logic [1:0] exp_op;
            exp_op = m[2] ? 2'd3 : (m[1] ? 2'd2 : (m[0] ? 2'd1 : 2'd0));
            request(m[0], m[1], m[2]);
            chk("R3 op priority", eng_op, exp_op);
            chk("R2 working", working, (exp_op != 0));
            chk("R2 start pulse", eng_start, (exp_op != 0));
            step();
            chk("R2 start one cycle", eng_start, 0);
            if (exp_op != 0) begin
                finish_op(1'b0);
                chk("R6 working cleared", working, 0);
                chk("R6 raw set", irq_raw, BIT2);
                clear_irq(BIT2);
                chk("R10 cleared", irq_raw, 0);
            end
        end

        // R4 / R5 / R7: busy behaviour and failure flags
        request(1, 0, 0);
        request(0, 1, 0);
        chk("R4 op kept", eng_op, 1);
        chk("R4 no start", eng_start, 0);
        chk("R4 working", working, 1);
        request(1, 0, 0);
        chk("R4 data ignored start", eng_start, 0);
        request(0, 0, 1);
        chk("R5 rejected", erase_rej, 1);
        chk("R5 op kept", eng_op, 1);
        chk("R5 no start", eng_start, 0);
        finish_op(1'b1);
        chk("R6 error done clears working", working, 0);
        chk("R6 error done raises raw", irq_raw, BIT2);
        chk("R7 prog fail", prog_fail, 1);
        chk("R7 erase fail clear", erase_fail, 0);
        chk("R5 reject sticky", erase_rej, 1);
        clear_irq(BIT2);
        request(0, 0, 1);
        chk("R7 flags cleared on accept", {prog_fail, erase_fail, erase_rej}, 0);
        chk("R2 erase op", eng_op, 3);
        finish_op(1'b1);
        chk("R7 erase fail", erase_fail, 1);
        chk("R7 prog fail clear", prog_fail, 0);
        clear_irq(BIT2);
        request(0, 1, 0);
        finish_op(1'b1);
        chk("R7 prot error is program failure", {prog_fail, erase_fail}, 2'b10);
        clear_irq(BIT2);

        // R6 done while idle ignored
        finish_op(1'b1);
        chk("R6 idle done raw", irq_raw, 0);
        chk("R6 idle done flags", {prog_fail, erase_fail}, 2'b10);
        chk("R6 idle working", working, 0);

        // R8 soft reset priority
        request(1, 0, 0);
        soft_rst = 1; eng_done = 1; eng_err = 1; erase_req = 1;
        step();
        quiet();
        chk("R8 working cleared", working, 0);
        chk("R8 op cleared", eng_op, 0);
        chk("R8 flags cleared", {prog_fail, erase_fail, erase_rej}, 0);
        chk("R8 no irq", irq_raw, 0);
        chk("R8 no start", eng_start, 0);
        soft_rst = 1; wr_req = 1;
        step();
        quiet();
        chk("R8 start blocked", working, 0);
        request(0, 0, 1);
        chk("R8 erase after drain accepted", eng_op, 3);
        finish_op(1'b0);

        // R9 mask sweep
        for (int mk = 0; mk < 2; mk++) begin
            for (int rv = 0; rv < 2; rv++) begin
                mask_wr = 1; mask_data = mk[0] ? 8'hFF : 8'hFB;
                clr_wr = 1; clr_data = BIT2;
                step();
                quiet();
                if (rv == 1) begin
                    request(1, 0, 0);
                    finish_op(1'b0);
                end
                chk("R9 raw word", irq_raw, rv[0] ? BIT2 : 8'h00);
                chk("R9 masked word", irq_mis, (mk[0] & rv[0]) ? BIT2 : 8'h00);
                chk("R9 irq line", irq, mk[0] & rv[0]);
            end
        end
        mask_wr = 1; mask_data = BIT2;
        step();
        quiet();
        chk("R9 mask only bit 2", irq, 1);

        // R10 write-one-to-clear
        clear_irq(8'hFB);
        chk("R10 other bits no effect", irq_raw, BIT2);
        clear_irq(8'h00);
        chk("R10 zero no effect", irq_raw, BIT2);
        request(0, 1, 0);
        clear_irq(BIT2);
        chk("R10 clear while busy", irq_raw, 0);
        eng_done = 1; clr_wr = 1; clr_data = BIT2;
        step();
        quiet();
        chk("R10 completion wins", irq_raw, BIT2);
        chk("R9 irq follows", irq, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule